// File: doc/BRIEF.md
# Floppy Controller Host Status and Phase Sequencer

This block is the processor-side front end of a floppy disk controller. It owns the 8-bit main status register that the host polls. It also steps the controller through three phases: command bytes arrive, the command executes, and result bytes are handed back. A command decoder alongside it consumes the forwarded command bytes and strobes back when a command is whole. An execution engine queues result bytes and signals when it is finished. A seek engine marks drives as seeking or settled.

The host sees a one-bit address. Address 0 is the status register. Address 1 is the data port: command bytes go in through it and result bytes come out of it. Writes are accepted only when the status register says the controller is asking for a byte in the host-to-controller direction. When an access command starts, the first result status byte is preloaded with the drive and head bits taken from the command. The host must read every queued result byte before the controller returns to waiting for a new command.

Top module: `fdc_host_status`

## Requirements
- R1: A synchronous active-high reset leaves the status register at 0x80 and the first result status byte (st0) at 0x00.
- R2: A host read with busAddr=0 returns the status register. Its layout is: bits 3..0 drive seeking (bit n for drive n), bit 4 command busy, bit 5 execution without DMA, bit 6 direction (1 = controller to host), bit 7 request for master.
- R3: A host write with busAddr=1 is forwarded on cmdByteValid/cmdByte only while bit 7 is 1 and bit 6 is 0. Writes with busAddr=0, and all writes during execution or result phases, are dropped and leave the status register unchanged.
- R4: A cmdDone strobe while waiting for command bytes clears bit 7 on the next cycle. For an access command it also sets bit 4 and loads st0 with {5'b0, cmdDriveHead}, where the head is in bit 2 and the unit in bits 1:0. For any other command, bit 4 stays 0 and st0 becomes 0.
- R5: Bit 5 is set during execution exactly when dmaMode is low at the cmdDone strobe, and it is never set outside execution.
- R6: An execDone pulse during execution clears bit 5 and sets bits 7 and 6 on the next cycle. Bit 4 keeps its value.
- R7: During execution, each resPush queues resData. In the result phase, host reads with busAddr=1 return the queued bytes in push order, one per read. Pushes beyond RES_DEPTH (default 8) entries are dropped.
- R8: On the read that takes the last queued byte, the next cycle shows bit 7=1, bit 6=0, bit 4=0 and bit 5=0. If the result phase starts with nothing queued, this idle state appears one cycle after the result phase began.
- R9: seekSet sets status bit seekDrive and seekClr clears it, in any phase. When both name the same drive in one cycle, the set wins.
- R10: A host read with busAddr=1 outside the result phase returns 0x00 and removes nothing from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe |
| busAddr | input | 1 | 0 = status register, 1 = data port |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Host read data |
| cmdByteValid | output | 1 | Accepted command byte strobe to the decoder |
| cmdByte | output | 8 | Command byte to the decoder |
| cmdDone | input | 1 | Decoder: command sequence complete |
| cmdIsAccess | input | 1 | Decoder: command is a media access |
| cmdDriveHead | input | 3 | Decoder: head (bit 2) and unit (bits 1:0) |
| dmaMode | input | 1 | Execution transfers use DMA |
| execDone | input | 1 | Execution finished pulse |
| resPush | input | 1 | Queue a result byte |
| resData | input | 8 | Result byte |
| seekSet | input | 1 | Mark drive seekDrive as seeking |
| seekClr | input | 1 | Mark drive seekDrive as settled |
| seekDrive | input | 2 | Drive index for seek marking |
| st0 | output | 8 | First result status byte |

## Verification
On every cycle the assertions check the phase edges that status bits expose. A cmdDone while requesting command bytes must drop the request. An execDone during execution must raise request and direction and drop the non-DMA flag. The non-DMA flag never coexists with a request, forwarded command bytes only appear while the request is up and the direction points inward, a seek set is visible the next cycle, and each return to idle clears the busy bit. Only the bench's scenarios show the data side: the order of queued result bytes, dropping of bytes past the queue depth, the st0 preload value, reads outside the result phase, and the exact cycle at which the idle status returns after the final read.

// File: rtl/fdc_status_pkg.sv
package fdc_status_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_t;

  // Status register bit positions (host software decodes these).
  localparam int MSR_RQM  = 7;
  localparam int MSR_DIO  = 6;
  localparam int MSR_NDMA = 5;
  localparam int MSR_BUSY = 4;

  // Strobes from the phase control to the datapath.
  typedef struct packed {
    logic setRqm;
    logic clrRqm;
    logic setDio;
    logic clrDio;
    logic setBusy;
    logic clrBusy;
    logic setNonDma;
    logic clrNonDma;
    logic clrSt0;
    logic loadSt0Head;
    logic push;
    logic pop;
  } dpStrobe_t;
endpackage

// File: rtl/fdc_phase_ctrl.sv
module fdc_phase_ctrl
  import fdc_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      busWr,
  input  logic      busRd,
  input  logic      busAddr,
  input  logic      cmdDone,
  input  logic      cmdIsAccess,
  input  logic      dmaMode,
  input  logic      execDone,
  input  logic      resPush,
  input  logic      rqm,
  input  logic      dio,
  input  logic      fifoEmpty,
  input  logic      fifoLast,
  output dpStrobe_t strb,
  output logic      inResult,
  output logic      cmdByteValid
);
  phase_t phase, nextPhase;
  logic   popOk;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_CMD;
    else     phase <= nextPhase;
  end

  always_comb begin
    strb      = '0;
    nextPhase = phase;
    popOk     = busRd & busAddr & (phase == PH_RES) & ~fifoEmpty;
    case (phase)
      PH_CMD: begin
        if (cmdDone) begin
          strb.clrRqm      = 1'b1;
          strb.clrSt0      = ~cmdIsAccess;
          strb.loadSt0Head = cmdIsAccess;
          strb.setBusy     = cmdIsAccess;
          strb.setNonDma   = ~dmaMode;
          nextPhase        = PH_EXEC;
        end
      end
      PH_EXEC: begin
        strb.push = resPush;
        if (execDone) begin
          strb.clrNonDma = 1'b1;
          strb.setRqm    = 1'b1;
          strb.setDio    = 1'b1;
          nextPhase      = PH_RES;
        end
      end
      PH_RES: begin
        strb.pop = popOk;
        if (fifoEmpty | (popOk & fifoLast)) begin
          strb.setRqm    = 1'b1;
          strb.clrDio    = 1'b1;
          strb.clrBusy   = 1'b1;
          strb.clrNonDma = 1'b1;
          nextPhase      = PH_CMD;
        end
      end
      default: nextPhase = PH_CMD;
    endcase
  end

  assign inResult     = (phase == PH_RES);
  assign cmdByteValid = busWr & busAddr & rqm & ~dio;
endmodule

// File: rtl/fdc_status_dp.sv
module fdc_status_dp
  import fdc_status_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int RES_DEPTH  = 8,
  localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  localparam int PTR_W = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1,
  localparam int CNT_W = PTR_W + 1
)(
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic [2:0]       driveHead,
  input  logic [7:0]       resData,
  input  logic             seekSet,
  input  logic             seekClr,
  input  logic [DRV_W-1:0] seekDrive,
  output logic [7:0]       msr,
  output logic [7:0]       st0,
  output logic [7:0]       fifoHead,
  output logic             fifoEmpty,
  output logic             fifoLast
);
  logic       rqm, dio, nonDma, busy;
  logic [3:0] seekBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      rqm <= 1'b1; dio <= 1'b0; nonDma <= 1'b0; busy <= 1'b0; st0 <= '0;
    end else begin
      if (strb.setRqm)         rqm    <= 1'b1;
      else if (strb.clrRqm)    rqm    <= 1'b0;
      if (strb.setDio)         dio    <= 1'b1;
      else if (strb.clrDio)    dio    <= 1'b0;
      if (strb.setNonDma)      nonDma <= 1'b1;
      else if (strb.clrNonDma) nonDma <= 1'b0;
      if (strb.setBusy)        busy   <= 1'b1;
      else if (strb.clrBusy)   busy   <= 1'b0;
      if (strb.loadSt0Head)    st0    <= {5'b0, driveHead};
      else if (strb.clrSt0)    st0    <= '0;
    end
  end

  for (genvar d = 0; d < 4; d++) begin : g_seek
    if (d < NUM_DRIVES) begin : g_on
      logic hit;
      assign hit = (seekDrive == DRV_W'(d));
      always_ff @(posedge clk) begin
        if (rst)                 seekBits[d] <= 1'b0;
        else if (seekSet & hit)  seekBits[d] <= 1'b1;
        else if (seekClr & hit)  seekBits[d] <= 1'b0;
      end
    end else begin : g_off
      assign seekBits[d] = 1'b0;
    end
  end

  assign msr = {rqm, dio, nonDma, busy, seekBits};

  // Result queue
  logic [7:0]       mem [RES_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;
  logic             doPush, doPop;

  assign doPush = strb.push & (cnt < CNT_W'(RES_DEPTH));
  assign doPop  = strb.pop & (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0; rdPtr <= '0; cnt <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= resData;
        wrPtr <= (wrPtr == PTR_W'(RES_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop)
        rdPtr <= (rdPtr == PTR_W'(RES_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      cnt <= cnt + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  assign fifoHead  = mem[rdPtr];
  assign fifoEmpty = (cnt == '0);
  assign fifoLast  = (cnt == CNT_W'(1));
endmodule

// File: rtl/fdc_host_status.sv
module fdc_host_status
  import fdc_status_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int RES_DEPTH  = 8
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       cmdByteValid,
  output logic [7:0] cmdByte,
  input  logic       cmdDone,
  input  logic       cmdIsAccess,
  input  logic [2:0] cmdDriveHead,
  input  logic       dmaMode,
  input  logic       execDone,
  input  logic       resPush,
  input  logic [7:0] resData,
  input  logic       seekSet,
  input  logic       seekClr,
  input  logic [1:0] seekDrive,
  output logic [7:0] st0
);
  dpStrobe_t  strb;
  logic [7:0] msr, fifoHead;
  logic       fifoEmpty, fifoLast, inResult;

  fdc_phase_ctrl u_ctrl (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .cmdDone(cmdDone), .cmdIsAccess(cmdIsAccess), .dmaMode(dmaMode),
    .execDone(execDone), .resPush(resPush),
    .rqm(msr[MSR_RQM]), .dio(msr[MSR_DIO]),
    .fifoEmpty(fifoEmpty), .fifoLast(fifoLast),
    .strb(strb), .inResult(inResult), .cmdByteValid(cmdByteValid)
  );

  fdc_status_dp #(.NUM_DRIVES(NUM_DRIVES), .RES_DEPTH(RES_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .driveHead(cmdDriveHead),
    .resData(resData), .seekSet(seekSet), .seekClr(seekClr),
    .seekDrive(seekDrive), .msr(msr), .st0(st0),
    .fifoHead(fifoHead), .fifoEmpty(fifoEmpty), .fifoLast(fifoLast)
  );

  assign cmdByte   = busWrData;
  assign busRdData = !busAddr ? msr : ((inResult & ~fifoEmpty) ? fifoHead : 8'h00);
endmodule

// File: rtl/fdc_status_chk.sv
module fdc_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       busWr,
  input logic       busAddr,
  input logic       cmdByteValid,
  input logic       cmdDone,
  input logic       execDone,
  input logic       seekSet,
  input logic       seekClr,
  input logic [1:0] seekDrive,
  input logic [7:0] msr,
  input logic [7:0] st0
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (msr == 8'h80 && st0 == 8'h00));

  // R3
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cmdByteValid |-> (busWr && busAddr && msr[7] && !msr[6]));

  // R4
  cmd_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (msr[7] && !msr[6] && cmdDone) |=> !msr[7]);

  // R5
  ndma_exec_chk: assert property (@(posedge clk) disable iff (rst)
    msr[5] |-> !msr[7]);

  // R6
  exec_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!msr[7] && execDone) |=> (msr[7] && msr[6] && !msr[5]));

  // R8
  idle_ret_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(msr[6]) |-> (msr[7] && !msr[4] && !msr[5]));

  // R9
  seek_set_chk: assert property (@(posedge clk) disable iff (rst)
    seekSet |=> ((msr[3:0] & (4'b0001 << $past(seekDrive))) != 4'b0));
endmodule

bind fdc_host_status fdc_status_chk u_chk (
  .clk(clk), .rst(rst), .busWr(busWr), .busAddr(busAddr),
  .cmdByteValid(cmdByteValid), .cmdDone(cmdDone), .execDone(execDone),
  .seekSet(seekSet), .seekClr(seekClr), .seekDrive(seekDrive),
  .msr(u_dp.msr), .st0(st0)
);

// File: tb/fdc_host_status_tb.sv
`timescale 1ns/100ps
module fdc_host_status_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busWr = 0, busRd = 0, busAddr = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] busRdData;
  logic cmdByteValid;
  logic [7:0] cmdByte;
  logic cmdDone = 0, cmdIsAccess = 0, dmaMode = 0, execDone = 0, resPush = 0;
  logic [2:0] cmdDriveHead = 0;
  logic [7:0] resData = 0;
  logic seekSet = 0, seekClr = 0;
  logic [1:0] seekDrive = 0;
  logic [7:0] st0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fdc_host_status u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic msrIs(string req, logic [7:0] exp);
    busAddr = 1'b0; #0.5;
    chk(req, busRdData, exp);
  endtask

  task automatic hostWrite(string req, logic a, logic [7:0] d, logic expFwd);
    @(negedge clk); busWr = 1; busAddr = a; busWrData = d; #0.5;
    chk(req, {7'b0, cmdByteValid}, {7'b0, expFwd});
    if (expFwd) chk(req, cmdByte, d);
    @(negedge clk); busWr = 0;
  endtask

  task automatic hostRead1(string req, logic [7:0] exp);
    @(negedge clk); busRd = 1; busAddr = 1; #0.5;
    chk(req, busRdData, exp);
    @(negedge clk); busRd = 0;
  endtask

  task automatic startCmd(logic acc, logic [2:0] dh, logic dma);
    @(negedge clk); cmdDone = 1; cmdIsAccess = acc; cmdDriveHead = dh; dmaMode = dma;
    @(negedge clk); cmdDone = 0;
  endtask

  task automatic pushBytes(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); resPush = 1; resData = base + 8'(i);
    end
    @(negedge clk); resPush = 0;
  endtask

  task automatic pulseExecDone();
    @(negedge clk); execDone = 1;
    @(negedge clk); execDone = 0;
  endtask

  task automatic seekOp(logic s, logic c, logic [1:0] d);
    @(negedge clk); seekSet = s; seekClr = c; seekDrive = d;
    @(negedge clk); seekSet = 0; seekClr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); msrIs("R1 status after reset", 8'h80);
    chk("R1 st0 after reset", st0, 8'h00);
  endtask

  task automatic t_write_gate_idle();
    hostWrite("R3 addr0 write dropped", 1'b0, 8'h5a, 1'b0);
    msrIs("R3 status unchanged", 8'h80);
    hostRead1("R10 data read while idle", 8'h00);
  endtask

  task automatic t_access_cmd();
    hostWrite("R3 command byte 0 forwarded", 1'b1, 8'h46, 1'b1);
    hostWrite("R3 command byte 1 forwarded", 1'b1, 8'h06, 1'b1);
    startCmd(1'b1, 3'b110, 1'b0);
    msrIs("R4 R5 access command no DMA", 8'h30);
    chk("R4 st0 preload", st0, 8'h06);
    hostWrite("R3 write during execution", 1'b1, 8'h11, 1'b0);
    msrIs("R3 status after dropped write", 8'h30);
    hostRead1("R10 data read during execution", 8'h00);
    pushBytes(3, 8'ha1);
    pulseExecDone();
    msrIs("R6 result phase entry", 8'hd0);
    hostWrite("R3 write during result phase", 1'b1, 8'h22, 1'b0);
    hostRead1("R7 result byte 0", 8'ha1);
    msrIs("R8 still in result phase", 8'hd0);
    hostRead1("R7 result byte 1", 8'ha2);
    hostRead1("R7 result byte 2", 8'ha3);
    msrIs("R8 idle after last read", 8'h80);
  endtask

  task automatic t_plain_cmd_dma();
    startCmd(1'b0, 3'b101, 1'b1);
    msrIs("R4 R5 non-access with DMA", 8'h00);
    chk("R4 st0 cleared on non-access", st0, 8'h00);
    pulseExecDone();
    msrIs("R6 empty result phase entry", 8'hc0);
    @(negedge clk);
    msrIs("R8 idle after empty result phase", 8'h80);
  endtask

  task automatic t_overflow();
    startCmd(1'b1, 3'b001, 1'b1);
    msrIs("R5 DMA access command", 8'h10);
    pushBytes(10, 8'h00);
    pulseExecDone();
    for (int i = 0; i < 8; i++) hostRead1("R7 queued byte order", 8'(i));
    msrIs("R7 R8 extra pushes dropped", 8'h80);
  endtask

  task automatic t_seek();
    seekOp(1, 0, 2'd2); msrIs("R9 set drive 2", 8'h84);
    seekOp(1, 0, 2'd0); msrIs("R9 set drive 0", 8'h85);
    seekOp(1, 1, 2'd2); msrIs("R9 set wins over clear", 8'h85);
    seekOp(0, 1, 2'd0); msrIs("R9 clear drive 0", 8'h84);
    startCmd(1'b1, 3'b011, 1'b0);
    msrIs("R2 R9 seek bit kept through command start", 8'h34);
    seekOp(0, 1, 2'd2); msrIs("R9 clear during execution", 8'h30);
    pulseExecDone();
    msrIs("R2 empty queue result entry", 8'hd0);
    @(negedge clk);
    msrIs("R8 idle again", 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_write_gate_idle();
    t_access_cmd();
    t_plain_cmd_dma();
    t_overflow();
    t_seek();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule